// File: doc/BRIEF.md
# FP8 to BF16 Vector Widening Converter

This block takes one 128-bit source vector and widens eight of its 8-bit floating-point bytes into eight BF16 values, packed into a 128-bit result. A half-select input chooses the low eight bytes or the high eight. A 32-bit mode word is presented with each operation. The block reads a 3-bit format code and a scale field from the mode word, and a variant bit chooses which of the two field pairs is used. Two 8-bit formats are decoded: one with a 5-bit exponent and 2-bit mantissa, and one with a 4-bit exponent and 3-bit mantissa. Each decoded value is scaled down by a power of two before it is packed into BF16.

The source bytes and mode fields are consumed in the cycle the operation is accepted, and the result is registered. A destination that aliases the source therefore never sees a partly written vector. A sticky invalid-operation flag collects the operations that met a signalling NaN or an unsupported format code. Every value the 8-bit formats can encode is exactly representable in BF16 after any allowed scale, so the conversion never rounds, overflows or underflows. Round-to-nearest-even is the fixed mode, and it never has to act. The only exception the block can raise is invalid.

Top module: `fp8_bf16_widen`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and low otherwise. `result` holds its value while no operation is accepted, and later changes on `src_vec` do not alter it.
- R2: With `upper_half` = 0, output lane i (`result[16i+15:16i]`) converts source byte i (`src_vec[8i+7:8i]`). With `upper_half` = 1, it converts source byte 8+i.
- R3: Format code 0 selects a sign, a 5-bit exponent (bias 15) and a 2-bit mantissa. Exponent 31 with mantissa 0 is a signed infinity (BF16 exponent 0xFF, mantissa 0). Exponent 31 with a nonzero mantissa is NaN. Exponent 0 gives signed zero or a subnormal, which is normalised exactly.
- R4: Format code 1 selects a sign, a 4-bit exponent (bias 7) and a 3-bit mantissa, with no infinity. Codes 0x7F and 0xFF are its only NaNs and never raise invalid, and its largest finite magnitude is 448.
- R5: Format codes 2 to 7 make every lane 0x7FC0 and raise the invalid flag.
- R6: With `variant_sel` = 0, the format code is `mode_word[2:0]` and the scale field is `mode_word[14:8]`. With `variant_sel` = 1, they are `mode_word[5:3]` and `mode_word[22:16]`.
- R7: Only the low 6 bits of the selected scale field count, and bit 6 of the field is ignored. Each lane equals the decoded input times 2 to the power of minus that 6-bit value, and the result is exact.
- R8: Every NaN result is 0x7FC0, whatever the input sign or payload. In format 0, a NaN whose mantissa has its upper bit clear (0x7D, 0xFD) raises invalid, and the other NaNs do not.
- R9: `exc_invalid` rises one cycle after an accepted operation that raises invalid. Once set, it stays set until reset.
- R10: While `rst_n` is low at a clock edge, `out_valid`, `result` and `exc_invalid` are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Accept one conversion this cycle |
| src_vec | input | 128 | Source vector, byte i at bits 8i+7:8i |
| variant_sel | input | 1 | Chooses which format/scale field pair of the mode word is used |
| upper_half | input | 1 | 0: bytes 0 to 7, 1: bytes 8 to 15 |
| mode_word | input | 32 | Format codes and scale fields for both variants |
| out_valid | output | 1 | Result valid, one cycle after acceptance |
| result | output | 128 | Eight BF16 lanes, lane i at bits 16i+15:16i |
| exc_invalid | output | 1 | Sticky invalid-operation flag |

## Verification
The hardest situations to reach from the ports are the ones that must leave the sticky flag untouched. Quiet NaNs in format 0 and the NaN codes of format 1 must not raise invalid. Once any signalling case has set the flag, this can no longer be observed. The stimulus therefore sweeps all of format 1 first and checks that the flag is still clear, then resets. It then feeds only quiet NaNs and infinities in format 0 before the first signalling NaN. Each operation places the unused field pair and the unused source half at values that would give a visibly different result, such as an unsupported code or signalling-NaN bytes. A wrong field or half selection therefore shows up in the output.

// File: rtl/fp8w_pkg.sv
// Shared constants and types for the FP8 to BF16 widening converter.
// Assumes BF16 uses a bias of 127 and 7 stored mantissa bits.
package fp8w_pkg;
    localparam int          FP8_W     = 8;
    localparam int          BF16_W    = 16;
    localparam int          FMT_W     = 3;
    localparam logic [15:0] BF16_DNAN = 16'h7FC0;

    typedef enum logic [2:0] {
        FMT_E5M2 = 3'd0,
        FMT_E4M3 = 3'd1
    } fp8_fmt_e;

    // Unpacked 8-bit value: exp is a two's-complement unbiased exponent,
    // frac holds three fraction bits below an implicit leading one.
    typedef struct packed {
        logic       is_nan;
        logic       is_snan;
        logic       is_inf;
        logic       is_zero;
        logic       sign;
        logic [7:0] exp;
        logic [2:0] frac;
    } fp8_parts_t;
endpackage

// File: rtl/fp8w_mode_pick.sv
// Chooses the format code and the effective scale from the mode word.
// Assumes the field positions given by the parameters. Only the low
// SCL_USE_W bits of the chosen scale field are passed on.
module fp8w_mode_pick import fp8w_pkg::*; #(
    parameter int MODE_W      = 32,
    parameter int FMT_LSB_A   = 0,
    parameter int FMT_LSB_B   = 3,
    parameter int SCL_LSB_A   = 8,
    parameter int SCL_LSB_B   = 16,
    parameter int SCL_FIELD_W = 7,
    parameter int SCL_USE_W   = 6
) (
    input  logic [MODE_W-1:0]    mode_word_i,
    input  logic                 variant_i,
    output logic [FMT_W-1:0]     fmt_o,
    output logic [SCL_USE_W-1:0] scale_o
);
    logic [SCL_FIELD_W-1:0] field_sel;
    logic                   unused_mode_bits;

    // Pick the field pair that belongs to the requested variant.
    always_comb begin
        if (variant_i) begin
            fmt_o     = mode_word_i[FMT_LSB_B +: FMT_W];
            field_sel = mode_word_i[SCL_LSB_B +: SCL_FIELD_W];
        end else begin
            fmt_o     = mode_word_i[FMT_LSB_A +: FMT_W];
            field_sel = mode_word_i[SCL_LSB_A +: SCL_FIELD_W];
        end
        scale_o = field_sel[SCL_USE_W-1:0];
    end

    assign unused_mode_bits = ^{mode_word_i, field_sel};
endmodule

// File: rtl/fp8w_decode.sv
// Unpacks one 8-bit float in either supported format into sign,
// unbiased exponent and normalised fraction. Subnormals are normalised
// here. Assumes the caller has already rejected unsupported format codes.
module fp8w_decode import fp8w_pkg::*; (
    input  logic [FP8_W-1:0] code_i,
    input  logic             fmt_e4m3_i,
    output fp8_parts_t       parts_o
);
    logic [4:0] ef;
    logic [2:0] fr;
    logic [7:0] bias;

    // Split the code into fields, then classify and normalise it.
    always_comb begin
        if (fmt_e4m3_i) begin
            ef   = {1'b0, code_i[6:3]};
            fr   = code_i[2:0];
            bias = 8'd7;
        end else begin
            ef   = code_i[6:2];
            fr   = {code_i[1:0], 1'b0};
            bias = 8'd15;
        end
        parts_o      = '0;
        parts_o.sign = code_i[7];
        if (!fmt_e4m3_i && ef == 5'd31) begin
            if (fr == 3'd0) begin
                parts_o.is_inf = 1'b1;
            end else begin
                parts_o.is_nan  = 1'b1;
                parts_o.is_snan = ~fr[2];
            end
        end else if (fmt_e4m3_i && ef == 5'd15 && fr == 3'd7) begin
            parts_o.is_nan = 1'b1;
        end else if (ef == 5'd0) begin
            if (fr == 3'd0) begin
                parts_o.is_zero = 1'b1;
            end else if (fr[2]) begin
                parts_o.exp  = 8'd0 - bias;
                parts_o.frac = {fr[1:0], 1'b0};
            end else if (fr[1]) begin
                parts_o.exp  = 8'hFF - bias;
                parts_o.frac = {fr[0], 2'b00};
            end else begin
                parts_o.exp  = 8'hFE - bias;
                parts_o.frac = 3'd0;
            end
        end else begin
            parts_o.exp  = {3'b000, ef} - bias;
            parts_o.frac = fr;
        end
    end
endmodule

// File: rtl/fp8w_encode.sv
// Packs unpacked parts, scaled down by 2**scale, into BF16. Assumes the
// scaled exponent always lands in the BF16 normal range, which holds
// for both input formats and any 6-bit scale, so no rounding is needed.
module fp8w_encode import fp8w_pkg::*; #(
    parameter int SCL_USE_W = 6
) (
    input  fp8_parts_t            parts_i,
    input  logic [SCL_USE_W-1:0]  scale_i,
    output logic [BF16_W-1:0]     bf_o
);
    localparam int EW = 10;

    logic signed [EW-1:0] biased;
    logic                 unused_high;

    // Rebias the exponent after subtracting the scale.
    always_comb begin
        biased = $signed({{(EW-8){parts_i.exp[7]}}, parts_i.exp})
               - $signed({{(EW-SCL_USE_W){1'b0}}, scale_i})
               + 10'sd127;
    end

    // Choose the special encodings first, then the finite value.
    always_comb begin
        if (parts_i.is_nan)       bf_o = BF16_DNAN;
        else if (parts_i.is_inf)  bf_o = {parts_i.sign, 8'hFF, 7'h00};
        else if (parts_i.is_zero) bf_o = {parts_i.sign, 15'h0000};
        else                      bf_o = {parts_i.sign, biased[7:0], parts_i.frac, 4'h0};
    end

    assign unused_high = ^{biased[EW-1:8], parts_i.is_snan};
endmodule

// File: rtl/fp8w_lane.sv
// One conversion lane: rejects unsupported format codes, otherwise
// decodes and packs. Reports whether this lane raises invalid.
module fp8w_lane import fp8w_pkg::*; #(
    parameter int SCL_USE_W = 6
) (
    input  logic [FP8_W-1:0]     code_i,
    input  logic [FMT_W-1:0]     fmt_i,
    input  logic [SCL_USE_W-1:0] scale_i,
    output logic [BF16_W-1:0]    bf_o,
    output logic                 invalid_o
);
    fp8_parts_t          parts;
    logic [BF16_W-1:0]   packed_bf;
    logic                supported;

    assign supported = (fmt_i == FMT_E5M2) || (fmt_i == FMT_E4M3);

    fp8w_decode u_dec (
        .code_i     (code_i),
        .fmt_e4m3_i (fmt_i == FMT_E4M3),
        .parts_o    (parts)
    );

    fp8w_encode #(.SCL_USE_W(SCL_USE_W)) u_enc (
        .parts_i (parts),
        .scale_i (scale_i),
        .bf_o    (packed_bf)
    );

    // Unsupported codes give the default NaN and an invalid signal.
    always_comb begin
        bf_o      = supported ? packed_bf : BF16_DNAN;
        invalid_o = supported ? parts.is_snan : 1'b1;
    end
endmodule

// File: rtl/fp8_bf16_widen.sv
// Top: widens eight 8-bit floats from one half of a 128-bit vector into
// eight BF16 lanes. Everything is read in the accepting cycle and the
// result is registered, so an aliased destination is safe. Keeps a
// sticky invalid flag. Synchronous active-low reset.
module fp8_bf16_widen import fp8w_pkg::*; #(
    parameter int LANES       = 8,
    parameter int MODE_W      = 32,
    parameter int FMT_LSB_A   = 0,
    parameter int FMT_LSB_B   = 3,
    parameter int SCL_LSB_A   = 8,
    parameter int SCL_LSB_B   = 16,
    parameter int SCL_FIELD_W = 7,
    parameter int SCL_USE_W   = 6,
    localparam int SRC_W      = 2 * LANES * FP8_W,
    localparam int RES_W      = LANES * BF16_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [SRC_W-1:0]  src_vec,
    input  logic              variant_sel,
    input  logic              upper_half,
    input  logic [MODE_W-1:0] mode_word,
    output logic              out_valid,
    output logic [RES_W-1:0]  result,
    output logic              exc_invalid
);
    logic [FMT_W-1:0]     sel_fmt;
    logic [SCL_USE_W-1:0] sel_scale;
    logic [RES_W-1:0]     lane_res;
    logic [LANES-1:0]     lane_inv;

    fp8w_mode_pick #(
        .MODE_W(MODE_W), .FMT_LSB_A(FMT_LSB_A), .FMT_LSB_B(FMT_LSB_B),
        .SCL_LSB_A(SCL_LSB_A), .SCL_LSB_B(SCL_LSB_B),
        .SCL_FIELD_W(SCL_FIELD_W), .SCL_USE_W(SCL_USE_W)
    ) u_pick (
        .mode_word_i (mode_word),
        .variant_i   (variant_sel),
        .fmt_o       (sel_fmt),
        .scale_o     (sel_scale)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [FP8_W-1:0] byte_sel;
        assign byte_sel = upper_half ? src_vec[(LANES+i)*FP8_W +: FP8_W]
                                     : src_vec[i*FP8_W +: FP8_W];
        fp8w_lane #(.SCL_USE_W(SCL_USE_W)) u_lane (
            .code_i    (byte_sel),
            .fmt_i     (sel_fmt),
            .scale_i   (sel_scale),
            .bf_o      (lane_res[i*BF16_W +: BF16_W]),
            .invalid_o (lane_inv[i])
        );
    end

    // Register the result and valid, and accumulate the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            result      <= '0;
            exc_invalid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result      <= lane_res;
                exc_invalid <= exc_invalid | (|lane_inv);
            end
        end
    end
endmodule

// File: rtl/fp8w_chk.sv
// Assertion checker for fp8_bf16_widen, attached by bind below.
module fp8w_chk #(
    parameter int LANES     = 8,
    parameter int MODE_W    = 32,
    parameter int FMT_LSB_A = 0,
    parameter int FMT_LSB_B = 3,
    localparam int SRC_W    = 2 * LANES * 8,
    localparam int RES_W    = LANES * 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [SRC_W-1:0]  src_vec,
    input logic              variant_sel,
    input logic              upper_half,
    input logic [MODE_W-1:0] mode_word,
    input logic              out_valid,
    input logic [RES_W-1:0]  result,
    input logic              exc_invalid
);
    logic [2:0] chk_fmt;
    assign chk_fmt = variant_sel ? mode_word[FMT_LSB_B +: 3] : mode_word[FMT_LSB_A +: 3];

    // R1
    accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result)));
    // R5
    unsupported_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && chk_fmt > 3'd1) |=> (result == {LANES{16'h7FC0}} && exc_invalid));
    // R9
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_invalid |=> exc_invalid);
    // R9
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_invalid && !in_valid) |=> !exc_invalid);
    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0 && !exc_invalid));
endmodule

bind fp8_bf16_widen fp8w_chk #(
    .LANES(LANES), .MODE_W(MODE_W), .FMT_LSB_A(FMT_LSB_A), .FMT_LSB_B(FMT_LSB_B)
) u_chk (.*);

// File: tb/sim_fp8_bf16_widen.sv
module sim_fp8_bf16_widen;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] src_vec = '0;
    logic         variant_sel = 1'b0;
    logic         upper_half = 1'b0;
    logic [31:0]  mode_word = '0;
    logic         out_valid;
    logic [127:0] result;
    logic         exc_invalid;

    int n_cmp = 0;
    int n_bad = 0;
    logic exp_inv = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp8_bf16_widen u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
        .variant_sel(variant_sel), .upper_half(upper_half), .mode_word(mode_word),
        .out_valid(out_valid), .result(result), .exc_invalid(exc_invalid)
    );

    function automatic real pow2(int n);
        real r = 1.0;
        if (n >= 0) for (int k = 0; k < n; k++) r = r * 2.0;
        else        for (int k = 0; k < -n; k++) r = r / 2.0;
        return r;
    endfunction

    // Behavioural model: real-valued decode, scale, then BF16 packing.
    function automatic logic [15:0] ref_conv(logic [7:0] code, int fmt, int scale, output bit inv);
        real mag;
        int  e, m, ex;
        bit  sgn = code[7];
        inv = 1'b0;
        if (fmt > 1) begin inv = 1'b1; return 16'h7FC0; end
        if (fmt == 0) begin
            e = int'(code[6:2]); m = int'(code[1:0]);
            if (e == 31) begin
                if (m == 0) return {sgn, 8'hFF, 7'h00};
                inv = (m < 2);
                return 16'h7FC0;
            end
            mag = (e == 0) ? (m / 4.0) * pow2(-14) : (1.0 + m / 4.0) * pow2(e - 15);
        end else begin
            e = int'(code[6:3]); m = int'(code[2:0]);
            if (e == 15 && m == 7) return 16'h7FC0;
            mag = (e == 0) ? (m / 8.0) * pow2(-6) : (1.0 + m / 8.0) * pow2(e - 7);
        end
        mag = mag * pow2(-scale);
        if (mag == 0.0) return {sgn, 15'h0000};
        ex = 0;
        while (mag >= 2.0) begin mag = mag / 2.0; ex++; end
        while (mag < 1.0)  begin mag = mag * 2.0; ex--; end
        return {sgn, 8'(ex + 127), 7'(int'((mag - 1.0) * 128.0))};
    endfunction

    function automatic logic [31:0] mk_mode(bit var_b, int fmt, int sfield, int ofmt, int osfield);
        logic [31:0] w = '0;
        if (var_b) begin
            w[5:3] = 3'(fmt);  w[22:16] = 7'(sfield);
            w[2:0] = 3'(ofmt); w[14:8]  = 7'(osfield);
        end else begin
            w[2:0] = 3'(fmt);  w[14:8]  = 7'(sfield);
            w[5:3] = 3'(ofmt); w[22:16] = 7'(osfield);
        end
        return w;
    endfunction

    task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One accepted operation; expected values derive from R2, R6, R7.
    task automatic run_op(string tag, logic [63:0] chosen, logic [63:0] other,
                          bit up, bit var_b, int fmt, int sfield, int ofmt, int osfield);
        logic [127:0] exp_res;
        bit inv;
        @(negedge clk);
        in_valid    = 1'b1;
        upper_half  = up;
        variant_sel = var_b;
        src_vec     = up ? {chosen, other} : {other, chosen};
        mode_word   = mk_mode(var_b, fmt, sfield, ofmt, osfield);
        for (int i = 0; i < 8; i++) begin
            exp_res[16*i +: 16] = ref_conv(chosen[8*i +: 8], fmt, sfield % 64, inv);
            exp_inv = exp_inv | inv;
        end
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " valid R1"}, {127'd0, out_valid}, 128'd1);
        check(tag, result, exp_res);
        check({tag, " flag R9"}, {127'd0, exc_invalid}, {127'd0, exp_inv});
    endtask

    task automatic idle_cycle(string tag);
        logic [127:0] held;
        held = result;
        @(negedge clk);
        in_valid = 1'b0;
        src_vec  = ~src_vec;
        @(negedge clk);
        check({tag, " idle valid R1"}, {127'd0, out_valid}, 128'd0);
        check({tag, " idle hold R1"}, result, held);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        exp_inv = 1'b0;
        check("R10 reset valid", {127'd0, out_valid}, 128'd0);
        check("R10 reset result", result, 128'd0);
        check("R10 reset flag", {127'd0, exc_invalid}, 128'd0);
    endtask

    task automatic sweep(int fmt, int sfield, string tag);
        for (int blk = 0; blk < 32; blk++) begin
            logic [63:0] ch;
            for (int i = 0; i < 8; i++) ch[8*i +: 8] = 8'(blk * 8 + i);
            run_op(tag, ch, {8{8'h7D}}, ((blk >> 1) & 1) == 1, (blk & 1) == 1,
                   fmt, sfield, 5, 33);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        do_reset();
        // R4 format 1 over all codes, R7 several scales incl. ignored bit 6 (field 127 -> 63)
        sweep(1, 0,   "R4 e4m3 s0 R2 R6");
        sweep(1, 1,   "R4 e4m3 s1 R7");
        sweep(1, 7,   "R4 e4m3 s7 R7");
        sweep(1, 63,  "R4 e4m3 s63 R7");
        sweep(1, 127, "R7 e4m3 bit6 ignored");
        // R4 its NaNs never raise invalid
        check("R4 e4m3 nan quiet flag", {127'd0, exc_invalid}, 128'd0);
        idle_cycle("R1 a");
        do_reset();
        // R8 quiet NaNs and infinities of format 0 do not set the flag
        run_op("R8 quiet nan R3 inf", {8'h7E, 8'h7F, 8'hFE, 8'hFF, 8'h7C, 8'hFC, 8'h00, 8'h80},
               64'h0, 1'b0, 1'b1, 0, 9, 1, 0);
        check("R8 quiet no flag", {127'd0, exc_invalid}, 128'd0);
        run_op("R8 snan R9 rise", {8'h01, 8'h02, 8'h03, 8'h7D, 8'h3C, 8'hBC, 8'h40, 8'h7B},
               64'h0, 1'b1, 1'b0, 0, 2, 1, 0);
        check("R9 flag set", {127'd0, exc_invalid}, 128'd1);
        idle_cycle("R9 hold");
        run_op("R9 stays set", {8{8'h3C}}, 64'h0, 1'b0, 1'b0, 0, 0, 1, 0);
        // R3 format 0 over all codes
        sweep(0, 0,  "R3 e5m2 s0");
        sweep(0, 5,  "R3 e5m2 s5 R7");
        sweep(0, 63, "R3 e5m2 s63 R7");
        sweep(0, 64, "R7 e5m2 bit6 ignored");
        do_reset();
        // R5 every unsupported code through both variants
        for (int f = 2; f < 8; f++) begin
            run_op("R5 unsupported", {8{8'h3C}}, {8{8'h40}}, f[0], f[1], f, 3, 0, 0);
        end
        idle_cycle("R1 b");
        idle_cycle("R1 c");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule